// File: doc/BRIEF.md
# Quad dual-source multiplexing latch

A four-bit storage element in which every bit picks one of two data sources and keeps the result. All bits share two active-low enables, a two-bit mode code and an active-high master reset. The latch takes new data only while both enables are low. When either enable is high, the stored word is held no matter what the data or mode inputs do.

The mode code selects one of four functions: pass source 0, pass source 1, force zero, or pass the bitwise OR of the two sources. If both mode bits are driven from one wire, the block reduces to a plain two-way selector. Each bit has a true output and a complementary output. The complementary output is kept in a register of its own.

This version is synchronous. A system clock samples the enables, the mode code and the data, so the transparent window is the set of clock edges at which both enables are low. The master reset acts asynchronously and overrides every other input. The word present before an enable rises is therefore the word captured at the last open edge.

Top module: `quad_mux_latch`

## Requirements
- R1: Raising rst clears q to all zeros and sets q_n to all ones at once, without waiting for a clock edge.
- R2: While rst is high, q stays zero whatever the enables, mode and data inputs do.
- R3: At a clock edge where en_a_n and en_b_n are both low, q takes the word chosen by mode from src0 and src1, visible after that edge.
- R4: Mode code 2'b00 passes src0 bit by bit.
- R5: Mode code 2'b11 passes src1 bit by bit.
- R6: Mode code 2'b10 passes src0 OR src1 bit by bit.
- R7: Mode code 2'b01 forces every bit of q low.
- R8: While en_a_n alone is high, q holds its stored word as src0, src1 and mode change.
- R9: While en_b_n alone is high, q holds its stored word as src0, src1 and mode change.
- R10: After an enable rises, q keeps the word captured at the last edge where both enables were low, until the enables reopen.
- R11: q_n is always the bitwise inverse of q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples enables, mode and data |
| rst | input | 1 | Master reset, active high, asynchronous |
| en_a_n | input | 1 | First enable, active low |
| en_b_n | input | 1 | Second enable, active low |
| mode | input | 2 | Mode code: 00 src0, 11 src1, 10 OR, 01 zero |
| src0 | input | WIDTH (4) | Source 0 data, one bit per slice |
| src1 | input | WIDTH (4) | Source 1 data, one bit per slice |
| q | output | WIDTH (4) | True outputs |
| q_n | output | WIDTH (4) | Complementary outputs |

## Verification
A load through an open latch, covering R3 to R7, shows on q one rising clock edge after the inputs are applied. The bench drives every input on a falling edge and checks on the next falling edge, after exactly one rising edge. A hold, covering R8 to R10, has to show no change at that same sampling point, and also at the one after it, while the inputs keep changing. The reset result of R1 takes no clock at all, so it is checked one nanosecond after rst rises, in the middle of a clock phase. Every check also compares q_n with the inverse of q, which covers R11.

// File: rtl/qml_pkg.sv
`timescale 1ns/1ps
package qml_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SRC0 = 2'b00,
    MODE_ZERO = 2'b01,
    MODE_OR   = 2'b10,
    MODE_SRC1 = 2'b11
  } qml_mode_e;

  // Result of one slice for a given mode and its two source bits.
  function automatic logic slice_pick(input qml_mode_e m, input logic a, input logic b);
    logic r;
    case (m)
      MODE_SRC0: r = a;
      MODE_SRC1: r = b;
      MODE_OR:   r = a | b;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // True when both active-low enables are asserted.
  function automatic logic gate_open(input logic ea_n, input logic eb_n);
    return ~(ea_n | eb_n);
  endfunction

endpackage

// File: rtl/qml_enable_track.sv
`timescale 1ns/1ps
module qml_enable_track (
  input  logic clk,
  input  logic rst,
  input  logic en_a_n,
  input  logic en_b_n,
  output logic open_now,
  output logic lock_evt
);
  import qml_pkg::*;

  logic open_q;

  assign open_now = gate_open(en_a_n, en_b_n);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= open_now;
  end

  // The latch was open at the previous edge and is closed at this one.
  assign lock_evt = open_q & ~open_now;

endmodule

// File: rtl/qml_slice_mux.sv
`timescale 1ns/1ps
module qml_slice_mux (
  input  qml_pkg::qml_mode_e mode,
  input  logic               a,
  input  logic               b,
  output logic               y
);
  import qml_pkg::*;

  assign y = slice_pick(mode, a, b);

endmodule

// File: rtl/qml_store.sv
`timescale 1ns/1ps
module qml_store #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // The complementary word lives in its own register bank.
  always_ff @(posedge clk or posedge rst) begin
    if (rst)       q_n <= '1;
    else if (load) q_n <= ~d;
  end

endmodule

// File: rtl/quad_mux_latch.sv
`timescale 1ns/1ps
module quad_mux_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] src0,
  input  logic [WIDTH-1:0] src1,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n
);
  import qml_pkg::*;

  qml_mode_e        mode_e;
  logic [WIDTH-1:0] pick_w;
  logic             open_w;
  logic             lock_w;

  assign mode_e = qml_mode_e'(mode);

  qml_enable_track i_track (
    .clk      (clk),
    .rst      (rst),
    .en_a_n   (en_a_n),
    .en_b_n   (en_b_n),
    .open_now (open_w),
    .lock_evt (lock_w)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    qml_slice_mux i_mux (
      .mode (mode_e),
      .a    (src0[g]),
      .b    (src1[g]),
      .y    (pick_w[g])
    );
  end

  qml_store #(.WIDTH(WIDTH)) i_store (
    .clk  (clk),
    .rst  (rst),
    .load (open_w),
    .d    (pick_w),
    .q    (q),
    .q_n  (q_n)
  );

endmodule

// File: rtl/qml_checker.sv
`timescale 1ns/1ps
module qml_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en_a_n,
  input logic             en_b_n,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] src0,
  input logic [WIDTH-1:0] src1,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] q_n,
  input logic             lock_w
);

  logic [WIDTH-1:0] ref_w;

  always_comb begin
    unique case (mode)
      2'b00:   ref_w = src0;
      2'b11:   ref_w = src1;
      2'b10:   ref_w = src0 | src1;
      default: ref_w = '0;
    endcase
  end

  always @(negedge clk) begin
    if (rst) begin
      AST_RESET_CLEARS: assert (q == '0 && q_n == '1); // R1
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      AST_COMPLEMENT: assert (q_n == ~q); // R11
    end
  end

  AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!en_a_n && !en_b_n) |=> (q == $past(ref_w))); // R3

  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    en_a_n |=> $stable(q)); // R8

  AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
    en_b_n |=> $stable(q)); // R9

  AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    lock_w |=> $stable(q)); // R10

endmodule

bind quad_mux_latch qml_checker #(.WIDTH(WIDTH)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .en_a_n (en_a_n),
  .en_b_n (en_b_n),
  .mode   (mode),
  .src0   (src0),
  .src1   (src1),
  .q      (q),
  .q_n    (q_n),
  .lock_w (lock_w)
);

// File: tb/test_quad_mux_latch.sv
`timescale 1ns/1ps
module test_quad_mux_latch;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en_a_n = 1'b1;
  logic         en_b_n = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] src0 = '0;
  logic [W-1:0] src1 = '0;
  logic [W-1:0] q;
  logic [W-1:0] q_n;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  quad_mux_latch #(.WIDTH(W)) i_quad_mux_latch (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .mode(mode), .src0(src0), .src1(src1), .q(q), .q_n(q_n)
  );

  function automatic logic [W-1:0] expect_word(input logic [1:0] m,
                                               input logic [W-1:0] a,
                                               input logic [W-1:0] b);
    if (m == 2'b01) return '0;
    if (m == 2'b00) return a;
    if (m == 2'b11) return b;
    return a | b;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_cmp++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
    n_cmp++;
    if (q_n !== ~exp) begin
      n_bad++;
      $display("FAIL R11 (%s): q_n=%b expected %b", tag, q_n, ~exp);
    end
  endtask

  // Drive on a falling edge, pass one rising edge, sample on the next falling edge.
  task automatic step(input logic ea, input logic eb, input logic [1:0] m,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    en_a_n = ea; en_b_n = eb; mode = m; src0 = a; src1 = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset state", '0);
    step(1'b0, 1'b0, 2'b00, 4'hF, 4'hF);
    check("R2 held in reset with open latch", '0);
    rst = 1'b0;
    step(1'b0, 1'b0, 2'b00, 4'h0, 4'h0);
    check("R3 after reset release", 4'h0);
  endtask

  task automatic t_modes(input logic [W-1:0] a, input logic [W-1:0] b);
    step(1'b0, 1'b0, 2'b00, a, b); check("R4 mode 00 src0", expect_word(2'b00, a, b));
    step(1'b0, 1'b0, 2'b11, a, b); check("R5 mode 11 src1", expect_word(2'b11, a, b));
    step(1'b0, 1'b0, 2'b10, a, b); check("R6 mode 10 OR",   expect_word(2'b10, a, b));
    step(1'b0, 1'b0, 2'b01, a, b); check("R7 mode 01 zero", expect_word(2'b01, a, b));
    step(1'b0, 1'b0, 2'b00, a, b); check("R3 reload src0",  expect_word(2'b00, a, b));
  endtask

  task automatic t_hold(input bit use_a);
    logic [W-1:0] kept;
    kept = 4'b1001;
    step(1'b0, 1'b0, 2'b00, kept, 4'b0110);
    check("R3 load before hold", kept);
    if (use_a) begin
      step(1'b1, 1'b0, 2'b11, 4'b0000, 4'b0110); check("R8 hold, en_a_n high", kept);
      step(1'b1, 1'b0, 2'b10, 4'b0101, 4'b0011); check("R8 hold, data moves", kept);
      step(1'b1, 1'b0, 2'b01, 4'b1111, 4'b1111); check("R10 captured word kept", kept);
    end else begin
      step(1'b0, 1'b1, 2'b11, 4'b0000, 4'b0110); check("R9 hold, en_b_n high", kept);
      step(1'b0, 1'b1, 2'b10, 4'b0101, 4'b0011); check("R9 hold, data moves", kept);
      step(1'b0, 1'b1, 2'b01, 4'b1111, 4'b1111); check("R10 captured word kept", kept);
    end
    step(1'b0, 1'b0, 2'b11, 4'b0000, 4'b0110);
    check("R3 reopen loads again", 4'b0110);
  endtask

  task automatic t_tied();
    step(1'b0, 1'b0, 2'b00, 4'b1100, 4'b0011); check("R4 tied low selects src0", 4'b1100);
    step(1'b0, 1'b0, 2'b11, 4'b1100, 4'b0011); check("R5 tied high selects src1", 4'b0011);
  endtask

  task automatic t_reset_latched();
    step(1'b0, 1'b0, 2'b00, 4'b1111, 4'b0000);
    check("R3 load before reset", 4'b1111);
    step(1'b1, 1'b1, 2'b00, 4'b0000, 4'b0000);
    check("R10 latched before reset", 4'b1111);
    #1 rst = 1'b1;
    #1 check("R1 asynchronous clear mid-phase", '0);
    @(negedge clk);
    step(1'b0, 1'b0, 2'b11, 4'b1111, 4'b1111);
    check("R2 stays clear during reset", '0);
    rst = 1'b0;
    step(1'b1, 1'b0, 2'b11, 4'b1111, 4'b1111);
    check("R8 hold after reset keeps zero", '0);
  endtask

  initial begin
    t_reset();
    t_modes(4'b1010, 4'b0110);
    t_modes(4'b0101, 4'b0011);
    t_hold(1'b1);
    t_hold(1'b0);
    t_tied();
    t_reset_latched();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule